// File: doc/BRIEF.md
# Aligned Erase Range Planner

The planner turns one erase request, given as a first 4 KB sector index and a number of sectors, into a sequence of flash erase commands. At every step it picks the largest erase unit allowed by the alignment of the current sector and by the number of sectors still to go: a 64 KB block, a 32 KB block or a single 4 KB sector. Each planned command leaves the block as an 8-bit opcode and a byte address under a valid/ready handshake, to be executed by a downstream flash command engine.

Once the whole range is covered, the planner raises a one-cycle completion pulse that carries the sector count the request asked for. A request for zero sectors completes at once and issues no command. Only one request is handled at a time, and only one command is ever outstanding. The serial transfers and the busy polling belong to the downstream engine.

Top module: `erase_range_planner`

## Requirements
- R1: Every command's byte address on `cmd_addr` equals the current sector index shifted left by 12, so its low 12 bits are zero.
- R2: When the current index is a multiple of 16 and at least 16 sectors remain, the command opcode is 0xD8 and the index then advances by 16.
- R3: Otherwise, when the index is a multiple of 8 and at least 8 sectors remain, the opcode is 0x52 and the index advances by 8.
- R4: In every other case the opcode is 0x20 and the index advances by 1.
- R5: The choice is made again after each accepted command, and commands continue until the remaining count reaches zero. The accepted commands cover exactly the requested contiguous range, and no unit is larger than the remainder.
- R6: In the cycle after the last command is accepted, `done_valid` is high for exactly one cycle and `done_count` equals the requested count.
- R7: A request with a count of zero produces no command, and `done_valid` with `done_count` = 0 in the cycle after acceptance.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_opcode` and `cmd_addr` hold their values.
- R9: `req_ready` is high only while the block is idle. A `req_valid` raised while busy has no effect on the command sequence or on the reported count.
- R10: After reset, and after a reset applied mid-run, `req_ready` is 1 and `cmd_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | Planner idle and accepting a request |
| req_start | input | IDX_W | First 4 KB sector index |
| req_count | input | CNT_W | Number of sectors to erase |
| cmd_valid | output | 1 | Erase command offered downstream |
| cmd_ready | input | 1 | Downstream engine takes the command |
| cmd_opcode | output | 8 | Erase opcode (0xD8, 0x52 or 0x20) |
| cmd_addr | output | IDX_W+12 | Byte address of the erase unit |
| done_valid | output | 1 | One-cycle completion pulse |
| done_count | output | CNT_W | Requested sector count, valid with done_valid |

## Verification
The bench targets ranges that begin off alignment and climb through single sectors to a 32 KB and then a 64 KB unit, runs whose remainder shrinks below a unit at an aligned index, a range at the top of the index space, and a zero count. A wrong priority or alignment test would send 4 KB erases where a block fits, or a block erase at a misaligned address that wipes sectors outside the range. A wrong remainder test would overshoot the range or stop short. Stalls on `cmd_ready` show whether a command changes or is lost before acceptance, and requests offered while busy show whether the planner restarts or mixes in the new range.

// File: rtl/erp_pkg.sv
package erp_pkg;

    // Erase units in priority order: largest first.
    localparam int NUM_UNITS = 3;
    localparam int unsigned UNIT_SHIFT [NUM_UNITS] = '{4, 3, 0};
    localparam logic [7:0]  UNIT_OPC   [NUM_UNITS] = '{8'hD8, 8'h52, 8'h20};

    // log2 of the sector size in bytes
    localparam int SECT_SHIFT = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } plan_state_e;

endpackage

// File: rtl/erp_unit_pick.sv
module erp_unit_pick
    import erp_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int CNT_W = 16
) (
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [CNT_W-1:0] cur_rem,
    output logic [7:0]       pick_opc,
    output logic [CNT_W-1:0] pick_step
);

    logic [NUM_UNITS-1:0] fits;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        localparam int SH = UNIT_SHIFT[u];
        logic aligned;
        logic enough;
        if (SH == 0) begin : g_any
            assign aligned = 1'b1;
        end else begin : g_mask
            assign aligned = (cur_idx[SH-1:0] == '0);
        end
        assign enough = (cur_rem >= CNT_W'(32'd1 << SH));
        assign fits[u] = aligned && enough;
    end

    // Walk from the smallest unit upward so the largest fitting unit wins.
    always_comb begin
        pick_opc  = UNIT_OPC[NUM_UNITS-1];
        pick_step = CNT_W'(32'd1 << UNIT_SHIFT[NUM_UNITS-1]);
        for (int u = NUM_UNITS - 1; u >= 0; u--) begin
            if (fits[u]) begin
                pick_opc  = UNIT_OPC[u];
                pick_step = CNT_W'(32'd1 << UNIT_SHIFT[u]);
            end
        end
    end

endmodule

// File: rtl/erp_addr_form.sv
module erp_addr_form #(
    parameter int IDX_W = 16,
    parameter int SHIFT = 12
) (
    input  logic [IDX_W-1:0]       sect_idx,
    output logic [IDX_W+SHIFT-1:0] byte_addr
);

    assign byte_addr = {sect_idx, {SHIFT{1'b0}}};

endmodule

// File: rtl/erase_range_planner.sv
module erase_range_planner
    import erp_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [IDX_W-1:0]           req_start,
    input  logic [CNT_W-1:0]           req_count,
    output logic                       cmd_valid,
    input  logic                       cmd_ready,
    output logic [7:0]                 cmd_opcode,
    output logic [IDX_W+SECT_SHIFT-1:0] cmd_addr,
    output logic                       done_valid,
    output logic [CNT_W-1:0]           done_count
);

    localparam int ADDR_W = IDX_W + SECT_SHIFT;

    typedef struct packed {
        plan_state_e      st;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] rem;
        logic [CNT_W-1:0] total;
    } plan_regs_t;

    plan_regs_t r_q;
    plan_regs_t r_d;

    logic [7:0]       step_opc;
    logic [CNT_W-1:0] step_len;
    logic [ADDR_W-1:0] step_addr;

    erp_unit_pick #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) pick_i (
        .cur_idx   (r_q.idx),
        .cur_rem   (r_q.rem),
        .pick_opc  (step_opc),
        .pick_step (step_len)
    );

    erp_addr_form #(
        .IDX_W (IDX_W),
        .SHIFT (SECT_SHIFT)
    ) addr_i (
        .sect_idx  (r_q.idx),
        .byte_addr (step_addr)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.idx   = req_start;
                    r_d.rem   = req_count;
                    r_d.total = req_count;
                    r_d.st    = (req_count == '0) ? ST_DONE : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) begin
                    r_d.idx = r_q.idx + IDX_W'(step_len);
                    r_d.rem = r_q.rem - step_len;
                    if (r_q.rem == step_len) begin
                        r_d.st = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.idx   <= '0;
            r_q.rem   <= '0;
            r_q.total <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign cmd_valid  = (r_q.st == ST_ISSUE);
    assign done_valid = (r_q.st == ST_DONE);
    assign done_count = r_q.total;
    assign cmd_opcode = step_opc;
    assign cmd_addr   = step_addr;

    // ---------------- assertions ----------------
    AST_ADDR_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_addr[SECT_SHIFT-1:0] == '0)); // R1

    AST_BIG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opcode == 8'hD8) |-> (cmd_addr[SECT_SHIFT+3:0] == '0)); // R2

    AST_MID_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opcode == 8'h52) |-> (cmd_addr[SECT_SHIFT+2:0] == '0)); // R3

    AST_OPC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_opcode == 8'hD8 || cmd_opcode == 8'h52 || cmd_opcode == 8'h20)); // R4

    AST_STEP_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (step_len <= r_q.rem)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R6

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_opcode) && $stable(cmd_addr))); // R8

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cmd_valid && !done_valid)); // R9

endmodule

// File: tb/erase_range_planner_tb_top.sv
module erase_range_planner_tb_top;

    localparam int IDX_W = 16;
    localparam int CNT_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [IDX_W-1:0]  req_start = '0;
    logic [CNT_W-1:0]  req_count = '0;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [7:0]        cmd_opcode;
    logic [IDX_W+11:0] cmd_addr;
    logic              done_valid;
    logic [CNT_W-1:0]  done_count;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    erase_range_planner #(.IDX_W(IDX_W), .CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_start  (req_start),
        .req_count  (req_count),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_opcode (cmd_opcode),
        .cmd_addr   (cmd_addr),
        .done_valid (done_valid),
        .done_count (done_count)
    );

    typedef struct packed {
        logic [15:0] start;
        logic [15:0] cnt;
        logic [7:0]  n64;
        logic [7:0]  n32;
        logic [15:0] n4;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 16'd16, 8'd1, 8'd0, 16'd0},
        '{16'h0000, 16'd24, 8'd1, 8'd1, 16'd0},
        '{16'h0003, 16'd5,  8'd0, 8'd0, 16'd5},
        '{16'h0005, 16'd30, 8'd1, 8'd1, 16'd6},
        '{16'h0010, 16'd15, 8'd0, 8'd1, 16'd7},
        '{16'h0000, 16'd1,  8'd0, 8'd0, 16'd1},
        '{16'h0030, 16'd40, 8'd2, 8'd1, 16'd0},
        '{16'h0008, 16'd8,  8'd0, 8'd1, 16'd0},
        '{16'hFFF0, 16'd16, 8'd1, 8'd0, 16'd0}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_step(input logic [15:0] i, input logic [15:0] r);
        if (i[3:0] == 4'd0 && r >= 16'd16) return 16;
        if (i[2:0] == 3'd0 && r >= 16'd8)  return 8;
        return 1;
    endfunction

    task automatic run_req(input logic [15:0] s, input logic [15:0] c, input logic [7:0] pat,
                           input bit noise, output int n64, output int n32, output int n4);
        logic [15:0] m_idx;
        logic [15:0] m_rem;
        bit          pv;
        bit          pr;
        logic [7:0]  p_op;
        logic [27:0] p_addr;
        int          cyc;
        int          st;
        bit          got_done;
        n64 = 0; n32 = 0; n4 = 0;
        m_idx = s; m_rem = c; pv = 0; pr = 0; p_op = '0; p_addr = '0; cyc = 0;
        got_done = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 idle ready", req_ready, 1);
        req_valid = 1'b1; req_start = s; req_count = c;
        @(negedge clk);
        if (noise) begin
            req_valid = 1'b1; req_start = 16'h0077; req_count = 16'd3;
        end else begin
            req_valid = 1'b0;
        end
        for (int k = 0; k < 4000 && !got_done; k++) begin
            cmd_ready = pat[cyc % 8];
            cyc++;
            if (pv && !pr) begin
                chk(cmd_valid == 1'b1, "R8 valid held", cmd_valid, 1);
                chk(cmd_opcode == p_op, "R8 opcode held", cmd_opcode, p_op);
                chk(cmd_addr == p_addr, "R8 addr held", cmd_addr, p_addr);
            end
            if (cmd_valid) begin
                st = exp_step(m_idx, m_rem);
                chk(req_ready == 1'b0, "R9 busy not ready", req_ready, 0);
                chk(cmd_addr == {m_idx, 12'h000}, "R1 byte address", cmd_addr, {m_idx, 12'h000});
                if (st == 16)     chk(cmd_opcode == 8'hD8, "R2 opcode", cmd_opcode, 8'hD8);
                else if (st == 8) chk(cmd_opcode == 8'h52, "R3 opcode", cmd_opcode, 8'h52);
                else              chk(cmd_opcode == 8'h20, "R4 opcode", cmd_opcode, 8'h20);
                if (cmd_ready) begin
                    if (st == 16) n64++; else if (st == 8) n32++; else n4++;
                    m_idx = m_idx + 16'(st);
                    m_rem = m_rem - 16'(st);
                end
            end
            if (done_valid) begin
                got_done = 1;
                chk(done_count == c, "R6 done count", done_count, c);
                chk(m_rem == 16'd0, "R5 range covered at done", m_rem, 0);
                chk(cmd_valid == 1'b0, "R6 no cmd with done", cmd_valid, 0);
                req_valid = 1'b0;
            end
            pv = cmd_valid; pr = cmd_ready; p_op = cmd_opcode; p_addr = cmd_addr;
            if (!got_done) @(negedge clk);
        end
        chk(got_done, "R5 run completes", got_done, 1);
        cmd_ready = 1'b0;
        @(negedge clk);
        chk(done_valid == 1'b0, "R6 done one cycle", done_valid, 0);
        chk(req_ready == 1'b1, "R9 idle after done", req_ready, 1);
        chk(cmd_valid == 1'b0, "R9 no stray cmd", cmd_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int a64, a32, a4;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10 reset req_ready", req_ready, 1);
        chk(cmd_valid == 1'b0, "R10 reset cmd_valid", cmd_valid, 0);
        chk(done_valid == 1'b0, "R10 reset done_valid", done_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            run_req(VECS[v].start, VECS[v].cnt, (v % 2 == 0) ? 8'hFF : 8'hA6, 1'b0, a64, a32, a4);
            chk(a64 == int'(VECS[v].n64), "R2 count of 64K units", a64, VECS[v].n64);
            chk(a32 == int'(VECS[v].n32), "R3 count of 32K units", a32, VECS[v].n32);
            chk(a4 == int'(VECS[v].n4), "R4 count of 4K units", a4, VECS[v].n4);
            chk(16 * a64 + 8 * a32 + a4 == int'(VECS[v].cnt), "R5 sectors covered",
                16 * a64 + 8 * a32 + a4, VECS[v].cnt);
        end

        // R9: requests offered while busy are ignored
        run_req(16'h0005, 16'd30, 8'h5B, 1'b1, a64, a32, a4);
        chk(a64 == 1 && a32 == 1 && a4 == 6, "R9 busy request ignored", a64 * 100 + a32 * 10 + a4, 116);

        // R7: zero count
        @(negedge clk);
        req_valid = 1'b1; req_start = 16'h0040; req_count = 16'd0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(cmd_valid == 1'b0, "R7 zero count no cmd", cmd_valid, 0);
        chk(done_valid == 1'b1, "R7 zero count done", done_valid, 1);
        chk(done_count == 16'd0, "R7 zero count value", done_count, 0);
        @(negedge clk);
        chk(done_valid == 1'b0, "R7 done pulse ends", done_valid, 0);
        chk(req_ready == 1'b1, "R7 idle again", req_ready, 1);

        // R10: reset in the middle of a run
        req_valid = 1'b1; req_start = 16'h0001; req_count = 16'd20; cmd_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(cmd_valid == 1'b1, "R10 run started", cmd_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R10 mid-run reset cmd_valid", cmd_valid, 0);
        chk(req_ready == 1'b1, "R10 mid-run reset req_ready", req_ready, 1);
        chk(done_valid == 1'b0, "R10 mid-run reset done_valid", done_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // After reset a fresh run still plans correctly
        run_req(16'h0018, 16'd9, 8'hFF, 1'b0, a64, a32, a4);
        chk(a64 == 0 && a32 == 1 && a4 == 1, "R3 plan after reset", a64 * 100 + a32 * 10 + a4, 11);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule